// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds received characters of a serial port until the host collects them. In queued mode, bytes from the deserialiser enter a 16-deep first-in first-out store. A programmable fill threshold and a character-timeout detector tell the host when to drain the store. In direct mode, a single holding register replaces the store. The block tracks arrival, line-break and overrun status and shows them to the host. The host sees the byte at the head of the store on `rd_data_o` and takes it away with a one-cycle `rd_i` strobe.

The host configures the block through an 8-bit control write. A one-cycle `stat_rd_i` strobe stands for a read of the line status and clears the sticky overrun and break indications. A tick from the baud generator marks every character time. The block does not deserialise the line and does not generate the baud rate.

Top module: `uart_rxq`

## Requirements
- R1: After reset, the count is 0, `rd_data_o` is 0, `fcr_o` is 0, the block is in direct mode, and data-ready, break, overrun, trigger and timeout are all low.
- R2: A control write stores only bits 7, 6, 3 and 0 of the written value, and `fcr_o` shows that stored value. Bit 0 selects queued mode (1) or direct mode (0). Bit 1 requests a receive reset. Bit 2 has no effect on this block.
- R3: In queued mode, bytes are returned in arrival order, and `count_o` follows every push and pop.
- R4: In queued mode, `trig_o` is high when the count is at least the threshold selected by control bits 7:6: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. In direct mode, `trig_o` follows data-ready.
- R5: A byte that arrives while the store holds 16 bytes, with no read in the same cycle, is dropped. It sets `ovr_o`, and the count stays at 16.
- R6: A control write with bit 1 set, or any control write that changes bit 0, empties the store and clears data-ready, break and timeout in the next cycle. Other inputs in that cycle are ignored.
- R7: In queued mode, each arrival restarts a timer of 4 character ticks. On the 4th tick, `tmo_o` rises if the store is not empty. After 3 ticks it is still low.
- R8: A read clears `tmo_o`. A read that leaves the store empty clears data-ready and break. A read that leaves bytes behind restarts the 4-tick timer.
- R9: A break strobe enters a zero byte and sets both `brk_o` and `data_rdy_o`. If both strobes are present, the break strobe takes precedence over a data byte.
- R10: In queued mode, `rd_data_o` is 0 while the store is empty.
- R11: In direct mode, an arriving byte overwrites the holding register and sets data-ready. If data-ready was already set and there is no read in the same cycle, the arrival also sets `ovr_o`.
- R12: A status-read strobe clears `ovr_o` and `brk_o` unless a new overrun or break is recorded in the same cycle. It does not change data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| brk_i | input | 1 | Line break detected strobe |
| char_tick_i | input | 1 | One pulse per character time |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write value |
| rd_i | input | 1 | Host takes the head byte |
| stat_rd_i | input | 1 | Host reads line status |
| rd_data_o | output | 8 | Head byte, or holding register in direct mode |
| data_rdy_o | output | 1 | Data ready |
| brk_o | output | 1 | Break received |
| ovr_o | output | 1 | Overrun |
| count_o | output | 5 | Bytes held in the store |
| trig_o | output | 1 | Fill threshold reached |
| tmo_o | output | 1 | Character timeout pending |
| fcr_o | output | 8 | Stored control value |

## Verification
The bench fills the store to its threshold, then to full, and then pushes one more byte. A design that wraps its count or overwrites the oldest byte would return a byte out of order or would not flag overrun. Timeout is probed at exactly the 3rd and 4th tick after an arrival and after a partial drain. A design that does not restart its timer on a read, or that counts one tick too many or too few, fails here. The bench also toggles the mode bit without setting the reset bit, to catch a design that resets only on the explicit bit. It covers break bytes, reads of an empty store, and direct-mode overwrite, where an overrun must be flagged while the newest byte is kept.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned FCR_EN    = 0;
  localparam int unsigned FCR_RXRST = 1;
  localparam logic [7:0]  FCR_KEEP  = 8'hC9;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);  // a same-cycle pop frees a slot
  assign dout_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [TW-1:0] cnt_q;
  logic          armed_q;

  assign expire_o = armed_q & tick_i & (cnt_q == TW'(LIMIT - 1)) & ~restart_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (stop_i || expire_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  input  logic          brk_i,
  input  logic          char_tick_i,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          rd_i,
  input  logic          stat_rd_i,
  output logic [7:0]    rd_data_o,
  output logic          data_rdy_o,
  output logic          brk_o,
  output logic          ovr_o,
  output logic [CW-1:0] count_o,
  output logic          trig_o,
  output logic          tmo_o,
  output logic [7:0]    fcr_o
);
  logic [7:0] fcr_q, hold_q, in_byte, head;
  logic       dr_q, brk_q, ovr_q, tmo_q;
  logic       fen, rx_rst, arrive, take, drain;
  logic       full, empty, lost, expire, restart;

  assign fen     = fcr_q[FCR_EN];
  // changing the mode bit implies a receive reset
  assign rx_rst  = cfg_we_i & (cfg_wdata_i[FCR_RXRST] | (cfg_wdata_i[FCR_EN] ^ fen));
  assign arrive  = (rx_valid_i | brk_i) & ~rx_rst;
  assign take    = rd_i & ~rx_rst;
  assign in_byte = brk_i ? 8'h00 : rx_data_i;
  assign drain   = take & ~arrive & (~fen | (count_o <= CW'(1)));
  assign lost    = arrive & (fen ? (full & ~take) : (dr_q & ~take));
  assign restart = fen & (arrive | (take & ~drain));

  uart_rxq_store #(.DEPTH(DEPTH), .W(8)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_rst),
    .push_i  (arrive & fen),
    .pop_i   (take & fen),
    .din_i   (in_byte),
    .dout_o  (head),
    .count_o (count_o),
    .full_o  (full),
    .empty_o (empty)
  );

  uart_rxq_timer #(.LIMIT(TMO_CHARS)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .stop_i    (rx_rst),
    .tick_i    (char_tick_i),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q  <= '0;
      hold_q <= '0;
      dr_q   <= 1'b0;
      brk_q  <= 1'b0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      if (cfg_we_i) fcr_q <= cfg_wdata_i & FCR_KEEP;
      if (arrive && !fen) hold_q <= in_byte;

      if (rx_rst)      dr_q <= 1'b0;
      else if (arrive) dr_q <= 1'b1;
      else if (drain)  dr_q <= 1'b0;

      if (rx_rst)                   brk_q <= 1'b0;
      else if (arrive && brk_i)     brk_q <= 1'b1;
      else if (drain || stat_rd_i)  brk_q <= 1'b0;

      if (lost)           ovr_q <= 1'b1;
      else if (stat_rd_i) ovr_q <= 1'b0;

      if (rx_rst || take)         tmo_q <= 1'b0;
      else if (expire && !empty)  tmo_q <= 1'b1;
    end
  end

  assign rd_data_o  = fen ? (empty ? 8'h00 : head) : hold_q;
  assign trig_o     = fen ? (int'(count_o) >= int'(trig_level(fcr_q[7:6]))) : dr_q;
  assign data_rdy_o = dr_q;
  assign brk_o      = brk_q;
  assign ovr_o      = ovr_q;
  assign tmo_o      = tmo_q;
  assign fcr_o      = fcr_q;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rd_i,
  input logic          cfg_we_i,
  input logic [7:0]    cfg_wdata_i,
  input logic [7:0]    fcr_o,
  input logic [CW-1:0] count_o,
  input logic          data_rdy_o,
  input logic          brk_o,
  input logic          ovr_o,
  input logic          tmo_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R5

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[0] && count_o == CW'(DEPTH) && rx_valid_i && !rd_i && !cfg_we_i)
    |=> (count_o == CW'(DEPTH) && ovr_o)); // R5

  AST_RX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[1]) |=> (count_o == '0 && !data_rdy_o && !brk_o && !tmo_o)); // R6

  AST_MODE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_wdata_i[0] != fcr_o[0])) |=> (count_o == '0 && !data_rdy_o)); // R6

  AST_FCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(fcr_o)); // R2

  AST_READ_CLR_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !tmo_o); // R8

  AST_TMO_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> count_o != '0); // R7

  AST_BRK_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> data_rdy_o); // R9
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rd_i        (rd_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .fcr_o       (fcr_o),
  .count_o     (count_o),
  .data_rdy_o  (data_rdy_o),
  .brk_o       (brk_o),
  .ovr_o       (ovr_o),
  .tmo_o       (tmo_o)
);

// File: tb/test_uart_rxq.sv
module test_uart_rxq;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_valid_i = 1'b0, brk_i = 1'b0, char_tick_i = 1'b0;
  logic       cfg_we_i = 1'b0, rd_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] rd_data_o, fcr_o;
  logic       data_rdy_o, brk_o, ovr_o, trig_o, tmo_o;
  logic [4:0] count_o;

  int   checks = 0, errors = 0;
  bit   mon_en = 0, done = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  uart_rxq i_uart_rxq (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each host read against the scoreboard (R3, R10)
  always @(negedge clk_i) begin
    if (rd_i && mon_en) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
      chk("R3 order / R10 empty", int'(rd_data_o), int'(e));
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic push(input logic [7:0] b);
    rx_data_i = b; rx_valid_i = 1'b1;
    if (mon_en && exp_q.size() < 16) exp_q.push_back(b);
    step();
    rx_valid_i = 1'b0;
  endtask

  task automatic brk_pulse();
    brk_i = 1'b1;
    if (mon_en && exp_q.size() < 16) exp_q.push_back(8'h00);
    step();
    brk_i = 1'b0;
  endtask

  task automatic host_rd();
    rd_i = 1'b1; step(); rd_i = 1'b0;
  endtask

  task automatic stat_rd();
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    cfg_wdata_i = v; cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick_i = 1'b1; step(); char_tick_i = 1'b0; step();
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    chk("R1 count", count_o, 0);
    chk("R1 flags", {data_rdy_o, brk_o, ovr_o, trig_o, tmo_o}, 0);
    chk("R1 fcr", fcr_o, 0);
    chk("R1 data", rd_data_o, 0);

    wr_fcr(8'hFF);
    chk("R2 masked fcr", fcr_o, 8'hC9);
    mon_en = 1;
    for (int i = 0; i < 13; i++) push(8'h10 + 8'(i));
    chk("R4 below 14", trig_o, 0);
    push(8'h1D);
    chk("R4 at 14", trig_o, 1);
    push(8'h1E); push(8'h1F);
    chk("R3 count full", count_o, 16);
    chk("R5 no ovr yet", ovr_o, 0);
    push(8'hEE);
    chk("R5 ovr", ovr_o, 1);
    chk("R5 count held", count_o, 16);
    for (int i = 0; i < 16; i++) host_rd();
    chk("R8 dr cleared", data_rdy_o, 0);
    chk("R3 count empty", count_o, 0);
    chk("R10 empty data", rd_data_o, 0);
    host_rd();
    stat_rd();
    chk("R12 ovr cleared", ovr_o, 0);

    wr_fcr(8'h41);
    chk("R6 no reset", fcr_o, 8'h41);
    push(8'h01); push(8'h02); push(8'h03);
    chk("R4 below 4", trig_o, 0);
    push(8'h04);
    chk("R4 at 4", trig_o, 1);
    wr_fcr(8'h43);
    exp_q.delete();
    chk("R6 count", count_o, 0);
    chk("R6 dr", data_rdy_o, 0);

    wr_fcr(8'h01);
    push(8'hA1); push(8'hA2);
    ticks(3);
    chk("R7 3 ticks", tmo_o, 0);
    ticks(1);
    chk("R7 4 ticks", tmo_o, 1);
    host_rd();
    chk("R8 tmo cleared", tmo_o, 0);
    chk("R8 dr kept", data_rdy_o, 1);
    ticks(3);
    chk("R8 restart 3", tmo_o, 0);
    ticks(1);
    chk("R8 restart 4", tmo_o, 1);
    host_rd();
    chk("R8 empty dr", data_rdy_o, 0);
    chk("R8 empty tmo", tmo_o, 0);

    brk_pulse();
    chk("R9 count", count_o, 1);
    chk("R9 brk", brk_o, 1);
    chk("R9 dr", data_rdy_o, 1);
    chk("R9 zero byte", rd_data_o, 0);
    stat_rd();
    chk("R12 brk cleared", brk_o, 0);
    chk("R12 dr kept", data_rdy_o, 1);
    host_rd();
    brk_pulse();
    host_rd();
    chk("R8 brk cleared on empty", brk_o, 0);

    push(8'hA5);
    ticks(4);
    chk("R7 tmo set", tmo_o, 1);
    wr_fcr(8'h00);
    mon_en = 0; exp_q.delete();
    chk("R6 toggle tmo", tmo_o, 0);
    chk("R6 toggle count", count_o, 0);
    chk("R6 toggle dr", data_rdy_o, 0);

    push(8'h3C);
    chk("R11 dr", data_rdy_o, 1);
    chk("R4 direct trig", trig_o, 1);
    chk("R11 data", rd_data_o, 8'h3C);
    chk("R11 no ovr", ovr_o, 0);
    push(8'h5A);
    chk("R11 ovr", ovr_o, 1);
    chk("R11 overwrite", rd_data_o, 8'h5A);
    host_rd();
    chk("R11 dr cleared", data_rdy_o, 0);
    stat_rd();
    chk("R12 direct ovr", ovr_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule